// File: doc/BRIEF.md
# Sequenced Clock Power-Down Controller

This block takes a clock generator's output domains down in a fixed order when an active-low, asynchronous power-down pin is driven low, and brings them back when the pin returns high. It controls four kinds of domain: a differential CPU pair, a free-running (non-stoppable) PCI clock, a 66 MHz buffer clock, and a parameterised group of other single-ended clocks. The power-down pin is sampled on the rising edge of the CPU complement clock. Each domain gates its own clock with an enable flop on that clock's falling edge, so an output can only stop or restart while its source is low. A domain reports that it has stopped back to the controller, and the controller waits for that report before it moves on to the next domain. Once every output is stopped, the controller raises a core-off signal that allows the PLLs and the rest of the generator to be shut down.

The sequencer state machine runs on the rising edge of the CPU complement clock and has six states:
- SEQ_RUN: all domains enabled.
- SEQ_STOP_FPCI: the free-running PCI clock is asked to stop.
- SEQ_STOP_B66: the 66 MHz buffer is asked to stop.
- SEQ_STOP_REST: the other clocks are asked to stop and the CPU pair is parked.
- SEQ_CORE_OFF: core-off is asserted.
- SEQ_LOCK_WAIT: core-off has been released and the lock-wait counter is counting down.

The transitions are:
- RUN to STOP_FPCI when power-down is recognised.
- STOP_FPCI to STOP_B66 when the PCI stop is acknowledged.
- STOP_B66 to STOP_REST when the buffer stop is acknowledged.
- STOP_REST to CORE_OFF when every other clock has stopped and the CPU pair is parked.
- CORE_OFF to LOCK_WAIT when the pin has been seen high twice.
- LOCK_WAIT to RUN when the counter reaches zero.

Top module: `pd_clk_sequencer`

## Requirements
- R1: Out of reset, every gated output follows its source clock, `core_off` is low and `cpu_c_oe` is high.
- R2: Power-down is recognised only when `pd_n` is low on two consecutive rising edges of `clk_cpu_c`. A single low sample has no effect on any output. Once power-down is recognised, the full stop sequence runs to `core_off` even if `pd_n` rises again.
- R3: The free-running PCI output `fpci_o` is the first to stop, and it stops only after recognition.
- R4: `b66_o` stops strictly after `fpci_o` has stopped.
- R5: Each bit of `rest_o` stops strictly after `b66_o` has stopped.
- R6: While the CPU pair is parked, `cpu_t_o` is high, `cpu_c_o` is low and `cpu_c_oe` is low (complement undriven). The pair is parked before `core_off` rises.
- R7: `core_off` rises only when every single-ended output is stopped low and the CPU pair is parked. These outputs stay in that state for as long as `core_off` is high.
- R8: Every high pulse on a gated single-ended output is a complete high phase of its source: it rises on the source's rising edge and falls on the source's falling edge, with no partial pulses.
- R9: While `core_off` is high, `core_off` clears on the third rising edge of `clk_cpu_c` after `pd_n` rises (two consecutive high samples).
- R10: No output restarts until at least `lock_cycles`+1 rising edges of `clk_cpu_c` after `core_off` clears. Every output is running again within `lock_cycles`+24 such edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| lock_cycles | input | LOCK_W | Lock-wait length, in CPU complement cycles, applied after core-off clears |
| clk_cpu_t | input | 1 | CPU true clock |
| clk_cpu_c | input | 1 | CPU complement clock; also the sequencer clock |
| clk_fpci | input | 1 | Free-running PCI source clock |
| clk_b66 | input | 1 | 66 MHz buffer source clock |
| clk_rest | input | N_REST | Other single-ended source clocks |
| cpu_t_o | output | 1 | Gated CPU true output; held high when parked |
| cpu_c_o | output | 1 | Gated CPU complement output; low when parked |
| cpu_c_oe | output | 1 | Drive enable for the complement output; low means undriven |
| fpci_o | output | 1 | Gated free-running PCI clock |
| b66_o | output | 1 | Gated 66 MHz buffer clock |
| rest_o | output | N_REST | Gated other clocks |
| core_off | output | 1 | Permission to power down the PLLs and core |

## Verification
If the sequencer state is wrong, the outputs stop in the wrong order. This shows up as a wrong ordering of the last falling edges, measured at the moment `core_off` rises, or as `core_off` rising while an output is still toggling, a few tens of complement cycles after the pin falls. If the enable flops are wrong, a clipped high pulse appears on the very clock edge where the enable changes. If the lock-wait count is wrong, an output restarts earlier or later than the window counted from the fall of `core_off`. If the pin-sampling logic is wrong, a one-sample glitch either stops the clocks, or a legitimate two-sample request fails to reach `core_off`.

// File: rtl/pdseq_pkg.sv
`timescale 1ns/1ps
package pdseq_pkg;

    typedef enum logic [2:0] {
        SEQ_RUN       = 3'd0,
        SEQ_STOP_FPCI = 3'd1,
        SEQ_STOP_B66  = 3'd2,
        SEQ_STOP_REST = 3'd3,
        SEQ_CORE_OFF  = 3'd4,
        SEQ_LOCK_WAIT = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic run_fpci;
        logic run_b66;
        logic run_rest;
        logic park_cpu;
        logic core_off;
    } seq_ctrl_t;

    localparam seq_ctrl_t CTRL_RESET = '{run_fpci: 1'b1, run_b66: 1'b1,
                                         run_rest: 1'b1, park_cpu: 1'b0,
                                         core_off: 1'b0};

endpackage

// File: rtl/pdseq_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer with a parameterised reset value.
module pdseq_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

endmodule

// File: rtl/pdseq_gate.sv
`timescale 1ns/1ps
// One single-ended domain: the run request is synchronized into this
// domain and applied on the falling edge, so the AND gate only switches
// while the source is low.
module pdseq_gate (
    input  logic clk_in,
    input  logic rst_n,
    input  logic run_req,
    output logic clk_out,
    output logic running
);

    logic run_s;
    logic en_q;

    pdseq_sync #(.W(1), .RST_VAL(1'b1)) u_run_sync (
        .clk   (clk_in),
        .rst_n (rst_n),
        .d     (run_req),
        .q     (run_s)
    );

    always_ff @(negedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b1;
        end else begin
            en_q <= run_s;
        end
    end

    assign clk_out = clk_in & en_q;
    assign running = en_q;

endmodule

// File: rtl/pdseq_park.sv
`timescale 1ns/1ps
// Differential CPU pair: parking takes effect on the complement's falling
// edge, where the true clock is already rising, so neither leg is chopped.
module pdseq_park (
    input  logic clk_cpu_t,
    input  logic clk_cpu_c,
    input  logic rst_n,
    input  logic park_req,
    output logic cpu_t_o,
    output logic cpu_c_o,
    output logic cpu_c_oe,
    output logic parked
);

    logic park_q;

    always_ff @(negedge clk_cpu_c or negedge rst_n) begin
        if (!rst_n) begin
            park_q <= 1'b0;
        end else begin
            park_q <= park_req;
        end
    end

    assign cpu_t_o  = clk_cpu_t | park_q;
    assign cpu_c_o  = clk_cpu_c & ~park_q;
    assign cpu_c_oe = ~park_q;
    assign parked   = park_q;

endmodule

// File: rtl/pdseq_fsm.sv
`timescale 1ns/1ps
module pdseq_fsm
    import pdseq_pkg::*;
#(
    parameter int N_REST = 3,
    parameter int LOCK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_n,
    input  logic [LOCK_W-1:0] lock_cycles,
    input  logic              ack_fpci_a,
    input  logic              ack_b66_a,
    input  logic [N_REST-1:0] ack_rest_a,
    input  logic              parked,
    output logic              run_fpci,
    output logic              run_b66,
    output logic              run_rest,
    output logic              park_req,
    output logic              core_off
);

    localparam int ACK_W = N_REST + 2;

    seq_state_e        state_q, state_d;
    seq_ctrl_t         ctrl_q;
    logic [LOCK_W-1:0] lock_cnt_q;
    logic              pd_q1, pd_q2;
    logic              pd_down, pd_up;
    logic [ACK_W-1:0]  ack_s;
    logic              fpci_stopped, b66_stopped, rest_stopped;

    // pin sampling: two consecutive samples decide in either direction
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pd_q1 <= 1'b1;
            pd_q2 <= 1'b1;
        end else begin
            pd_q1 <= pd_n;
            pd_q2 <= pd_q1;
        end
    end

    assign pd_down = ~pd_q1 & ~pd_q2;
    assign pd_up   =  pd_q1 &  pd_q2;

    pdseq_sync #(.W(ACK_W), .RST_VAL({ACK_W{1'b1}})) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ack_rest_a, ack_b66_a, ack_fpci_a}),
        .q     (ack_s)
    );

    assign fpci_stopped = ~ack_s[0];
    assign b66_stopped  = ~ack_s[1];
    assign rest_stopped = ~|ack_s[ACK_W-1:2];

    function automatic seq_ctrl_t decode(seq_state_e s);
        seq_ctrl_t c;
        c = CTRL_RESET;
        unique case (s)
            SEQ_RUN: begin
                c = CTRL_RESET;
            end
            SEQ_STOP_FPCI: begin
                c.run_fpci = 1'b0;
            end
            SEQ_STOP_B66: begin
                c.run_fpci = 1'b0;
                c.run_b66  = 1'b0;
            end
            SEQ_STOP_REST, SEQ_LOCK_WAIT: begin
                c.run_fpci = 1'b0;
                c.run_b66  = 1'b0;
                c.run_rest = 1'b0;
                c.park_cpu = 1'b1;
            end
            SEQ_CORE_OFF: begin
                c.run_fpci = 1'b0;
                c.run_b66  = 1'b0;
                c.run_rest = 1'b0;
                c.park_cpu = 1'b1;
                c.core_off = 1'b1;
            end
            default: begin
                c = CTRL_RESET;
            end
        endcase
        return c;
    endfunction

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_RUN: begin
                if (pd_down) state_d = SEQ_STOP_FPCI;
            end
            SEQ_STOP_FPCI: begin
                if (fpci_stopped) state_d = SEQ_STOP_B66;
            end
            SEQ_STOP_B66: begin
                if (b66_stopped) state_d = SEQ_STOP_REST;
            end
            SEQ_STOP_REST: begin
                if (rest_stopped && parked) state_d = SEQ_CORE_OFF;
            end
            SEQ_CORE_OFF: begin
                if (pd_up) state_d = SEQ_LOCK_WAIT;
            end
            SEQ_LOCK_WAIT: begin
                if (lock_cnt_q == '0) state_d = SEQ_RUN;
            end
            default: begin
                state_d = SEQ_RUN;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // lock-wait counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_cnt_q <= '0;
        end else if (state_q == SEQ_CORE_OFF && pd_up) begin
            lock_cnt_q <= lock_cycles;
        end else if (state_q == SEQ_LOCK_WAIT && lock_cnt_q != '0) begin
            lock_cnt_q <= lock_cnt_q - 1'b1;
        end
    end

    // registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
        end else begin
            ctrl_q <= decode(state_d);
        end
    end

    assign run_fpci = ctrl_q.run_fpci;
    assign run_b66  = ctrl_q.run_b66;
    assign run_rest = ctrl_q.run_rest;
    assign park_req = ctrl_q.park_cpu;
    assign core_off = ctrl_q.core_off;

    // R2
    recog_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_fpci) |-> (!$past(pd_q1) && !$past(pd_q2)));

    // R4
    b66_after_fpci_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_b66) |-> !$past(ack_s[0]));

    // R5
    rest_after_b66_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_rest) |-> !$past(ack_s[1]));

    // R7
    core_off_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_off) |-> ($past(ack_s) == '0 && $past(parked)));

    // R10
    lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_fpci) |-> !$past(core_off));

endmodule

// File: rtl/pd_clk_sequencer.sv
`timescale 1ns/1ps
module pd_clk_sequencer #(
    parameter int N_REST = 3,
    parameter int LOCK_W = 8
) (
    input  logic              rst_n,
    input  logic              pd_n,
    input  logic [LOCK_W-1:0] lock_cycles,
    input  logic              clk_cpu_t,
    input  logic              clk_cpu_c,
    input  logic              clk_fpci,
    input  logic              clk_b66,
    input  logic [N_REST-1:0] clk_rest,
    output logic              cpu_t_o,
    output logic              cpu_c_o,
    output logic              cpu_c_oe,
    output logic              fpci_o,
    output logic              b66_o,
    output logic [N_REST-1:0] rest_o,
    output logic              core_off
);

    logic              run_fpci, run_b66, run_rest, park_req, parked;
    logic              ack_fpci, ack_b66;
    logic [N_REST-1:0] ack_rest;

    pdseq_fsm #(.N_REST(N_REST), .LOCK_W(LOCK_W)) u_fsm (
        .clk         (clk_cpu_c),
        .rst_n       (rst_n),
        .pd_n        (pd_n),
        .lock_cycles (lock_cycles),
        .ack_fpci_a  (ack_fpci),
        .ack_b66_a   (ack_b66),
        .ack_rest_a  (ack_rest),
        .parked      (parked),
        .run_fpci    (run_fpci),
        .run_b66     (run_b66),
        .run_rest    (run_rest),
        .park_req    (park_req),
        .core_off    (core_off)
    );

    pdseq_gate u_gate_fpci (
        .clk_in  (clk_fpci),
        .rst_n   (rst_n),
        .run_req (run_fpci),
        .clk_out (fpci_o),
        .running (ack_fpci)
    );

    pdseq_gate u_gate_b66 (
        .clk_in  (clk_b66),
        .rst_n   (rst_n),
        .run_req (run_b66),
        .clk_out (b66_o),
        .running (ack_b66)
    );

    for (genvar g = 0; g < N_REST; g++) begin : g_rest
        pdseq_gate u_gate_rest (
            .clk_in  (clk_rest[g]),
            .rst_n   (rst_n),
            .run_req (run_rest),
            .clk_out (rest_o[g]),
            .running (ack_rest[g])
        );
    end

    pdseq_park u_park (
        .clk_cpu_t (clk_cpu_t),
        .clk_cpu_c (clk_cpu_c),
        .rst_n     (rst_n),
        .park_req  (park_req),
        .cpu_t_o   (cpu_t_o),
        .cpu_c_o   (cpu_c_o),
        .cpu_c_oe  (cpu_c_oe),
        .parked    (parked)
    );

endmodule

// File: tb/pd_clk_sequencer_bench.sv
`timescale 1ns/1ps
module pd_clk_sequencer_bench;

    localparam int NR = 3;
    localparam int LW = 8;
    localparam int ND = NR + 2;

    logic rst_n = 1'b1;
    logic pd_n = 1'b1;
    logic [LW-1:0] lock_cycles = 8'd5;
    logic cpuc = 1'b0;
    logic cput;
    logic fpci = 1'b0, b66 = 1'b0, r0 = 1'b0, r1 = 1'b0, r2 = 1'b0;
    logic [NR-1:0] clk_rest;
    logic cpu_t_o, cpu_c_o, cpu_c_oe, fpci_o, b66_o, core_off;
    logic [NR-1:0] rest_o;
    logic [ND-1:0] src_v, out_v;

    int checks = 0;
    int fails = 0;
    bit mon_on = 1'b0;
    int cur_lock = 5;

    realtime src_rise_t[ND], src_fall_t[ND], out_fall_t[ND];
    int rise_n[ND];
    int first_rise[ND];
    realtime t_recog = 0.0;
    int low_cnt = 0;
    bit waiting = 1'b0;
    int wait_cnt = 0;
    int co_seen = 0;
    int oe_drop_n = 0;

    assign cput = ~cpuc;
    assign clk_rest = {r2, r1, r0};
    assign src_v = {clk_rest, b66, fpci};
    assign out_v = {rest_o, b66_o, fpci_o};

    always #2 cpuc = ~cpuc;
    initial begin #0.5;  forever #6 fpci = ~fpci; end
    initial begin #0.7;  forever #4 b66  = ~b66;  end
    initial begin #0.3;  forever #3 r0   = ~r0;   end
    initial begin #1.1;  forever #5 r1   = ~r1;   end
    initial begin #0.9;  forever #7 r2   = ~r2;   end

    pd_clk_sequencer #(.N_REST(NR), .LOCK_W(LW)) u_pd_clk_sequencer (
        .rst_n       (rst_n),
        .pd_n        (pd_n),
        .lock_cycles (lock_cycles),
        .clk_cpu_t   (cput),
        .clk_cpu_c   (cpuc),
        .clk_fpci    (fpci),
        .clk_b66     (b66),
        .clk_rest    (clk_rest),
        .cpu_t_o     (cpu_t_o),
        .cpu_c_o     (cpu_c_o),
        .cpu_c_oe    (cpu_c_oe),
        .fpci_o      (fpci_o),
        .b66_o       (b66_o),
        .rest_o      (rest_o),
        .core_off    (core_off)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic longint ps(input realtime t);
        return longint'(t * 1000.0);
    endfunction

    // behavioural model of each domain: pulse integrity, stop times, restart
    for (genvar g = 0; g < ND; g++) begin : g_mon
        always @(posedge src_v[g]) src_rise_t[g] = $realtime;
        always @(negedge src_v[g]) src_fall_t[g] = $realtime;
        always @(posedge out_v[g]) begin
            if (mon_on) begin
                realtime t;
                t = $realtime;
                #0.001;
                rise_n[g]++;
                // R8 rising edge coincides with the source rising edge
                check(src_rise_t[g] == t, "R8", $sformatf("rise domain %0d ps", g),
                      ps(src_rise_t[g]), ps(t));
                if (waiting && first_rise[g] < 0) begin
                    first_rise[g] = wait_cnt;
                    // R10 no restart before lock_cycles+1 edges
                    check(wait_cnt > cur_lock, "R10", $sformatf("restart edge domain %0d", g),
                          wait_cnt, cur_lock + 1);
                end
            end
        end
        always @(negedge out_v[g]) begin
            if (mon_on) begin
                realtime t;
                t = $realtime;
                #0.001;
                out_fall_t[g] = t;
                // R8 falling edge coincides with the source falling edge
                check(src_fall_t[g] == t, "R8", $sformatf("fall domain %0d ps", g),
                      ps(src_fall_t[g]), ps(t));
            end
        end
    end

    always @(posedge cpuc) begin
        if (!pd_n) low_cnt++;
        else       low_cnt = 0;
        if (low_cnt == 2) t_recog = $realtime;
        if (waiting) wait_cnt++;
    end

    always @(negedge cpu_c_oe) if (mon_on) oe_drop_n++;

    always @(posedge core_off) begin
        if (mon_on) begin
            #0.001;
            co_seen++;
            // R3 PCI stopped after recognition
            check(out_fall_t[0] >= t_recog, "R3", "fpci stop vs recognition ps",
                  ps(out_fall_t[0]), ps(t_recog));
            // R4
            check(out_fall_t[1] > out_fall_t[0], "R4", "b66 stop after fpci ps",
                  ps(out_fall_t[1]), ps(out_fall_t[0]));
            for (int k = 2; k < ND; k++)
                // R5
                check(out_fall_t[k] > out_fall_t[1], "R5", $sformatf("rest %0d stop after b66 ps", k - 2),
                      ps(out_fall_t[k]), ps(out_fall_t[1]));
            // R7
            check(out_v == '0, "R7", "outputs low at core_off", out_v, 0);
            // R6
            check(cpu_t_o && !cpu_c_o && !cpu_c_oe, "R6", "cpu pair parked {t,c,oe}",
                  {cpu_t_o, cpu_c_o, cpu_c_oe}, 3'b100);
        end
    end

    always @(negedge core_off) begin
        if (mon_on) begin
            waiting = 1'b1;
            wait_cnt = 0;
            for (int k = 0; k < ND; k++) first_rise[k] = -1;
        end
    end

    task automatic wait_restart();
        bit done;
        done = 1'b0;
        for (int n = 0; n < cur_lock + 80 && !done; n++) begin
            @(negedge cpuc);
            done = 1'b1;
            for (int k = 0; k < ND; k++) if (first_rise[k] < 0) done = 1'b0;
        end
        waiting = 1'b0;
        for (int k = 0; k < ND; k++)
            // R10 upper bound on restart
            check(first_rise[k] >= 0 && first_rise[k] <= cur_lock + 24, "R10",
                  $sformatf("restart bound domain %0d", k), first_rise[k], cur_lock + 24);
    endtask

    task automatic wait_core_off(input string req);
        int n;
        n = 0;
        while (!core_off && n < 400) begin
            @(negedge cpuc);
            n++;
        end
        check(core_off == 1'b1, req, "core_off reached", core_off, 1);
    endtask

    task automatic power_cycle(input int lock);
        int n;
        cur_lock = lock;
        lock_cycles = LW'(lock);
        @(negedge cpuc);
        pd_n = 1'b0;
        wait_core_off("R7");
        for (int c = 0; c < 20; c++) begin
            @(negedge cpuc);
            // R7 hold while core_off
            check(out_v == '0 && core_off, "R7", "held stopped", out_v, 0);
            // R6
            check(cpu_t_o && !cpu_c_oe && !cpu_c_o, "R6", "pair parked during hold",
                  {cpu_t_o, cpu_c_o, cpu_c_oe}, 3'b100);
        end
        pd_n = 1'b1;
        n = 0;
        while (core_off && n < 10) begin
            @(posedge cpuc);
            n++;
            #0.5;
        end
        // R9
        check(n == 3, "R9", "edges until core_off clears", n, 3);
        wait_restart();
    endtask

    initial begin
        int snap[ND];
        int co0, oe0;
        bit ok;
        for (int k = 0; k < ND; k++) begin
            first_rise[k] = -1;
            rise_n[k] = 0;
            out_fall_t[k] = 0.0;
        end
        #1 rst_n = 1'b0;
        repeat (5) @(negedge cpuc);
        rst_n = 1'b1;
        repeat (3) @(negedge cpuc);
        mon_on = 1'b1;
        for (int k = 0; k < ND; k++) snap[k] = rise_n[k];
        repeat (20) @(negedge cpuc);
        // R1 reset state
        check(!core_off, "R1", "core_off after reset", core_off, 0);
        check(cpu_c_oe, "R1", "cpu_c_oe after reset", cpu_c_oe, 1);
        for (int k = 0; k < ND; k++)
            check(rise_n[k] > snap[k], "R1", $sformatf("domain %0d running", k), rise_n[k] - snap[k], 1);

        // R2 single low sample is ignored
        co0 = co_seen;
        oe0 = oe_drop_n;
        for (int k = 0; k < ND; k++) snap[k] = rise_n[k];
        @(negedge cpuc);
        pd_n = 1'b0;
        @(negedge cpuc);
        pd_n = 1'b1;
        repeat (60) @(negedge cpuc);
        check(co_seen == co0, "R2", "core_off after one sample", co_seen - co0, 0);
        check(oe_drop_n == oe0, "R2", "pair not parked after one sample", oe_drop_n - oe0, 0);
        ok = 1'b1;
        for (int k = 0; k < ND; k++) if (rise_n[k] - snap[k] < 7) ok = 1'b0;
        check(ok, "R2", "all domains kept running", ok, 1);

        power_cycle(5);
        power_cycle(0);
        power_cycle(40);

        // R2 exactly two low samples commit the full sequence
        cur_lock = 3;
        lock_cycles = 8'd3;
        co0 = co_seen;
        @(negedge cpuc);
        pd_n = 1'b0;
        @(posedge cpuc);
        @(posedge cpuc);
        @(negedge cpuc);
        pd_n = 1'b1;
        wait_core_off("R2");
        check(co_seen == co0 + 1, "R2", "sequence completed after two samples", co_seen - co0, 1);
        wait_restart();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4.0);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule